// File: doc/BRIEF.md
# Packed Quadword Low-to-High Merge Unit

This unit executes one vector register-merge operation and checks whether its encoding is legal. It takes the low 64 bits of a register operand and places them in bits 127:64 of the destination. What happens to the rest of the destination depends on the encoding class. In the legacy two-operand class, the destination's own low quadword and every bit above 127 are kept. In the two three-operand classes, the low quadword comes from a second source operand and every bit above 127 is cleared. All values are moved as raw bits. Floating-point encodings such as NaN or denormal patterns are never interpreted, and no floating-point exception exists.

The caller supplies a decoded encoding class, the two-bit addressing-mode field, the length bits, the W bit and three full-width operands: the current destination, the extra-source register and the register/memory register. A one-cycle `in_valid` strobe gives, on the next clock, a one-cycle `out_valid`. With it comes either a write-enable and a result, or an invalid-opcode flag. The output stage is a three-state machine:
- `ST_IDLE`: no result.
- `ST_COMMIT`: legal operation, result written.
- `ST_FAULT`: illegal encoding.

Each clock, the next state is chosen as follows:
- `ST_COMMIT` when `in_valid` is high and the encoding is legal.
- `ST_FAULT` when `in_valid` is high and the encoding is illegal.
- `ST_IDLE` when `in_valid` is low.

Reset forces `ST_IDLE`.

Top module: `qlh_merge`

## Requirements
- R1: With `enc`=0 (legacy), a committed result has bits 127:64 equal to `src_rm[63:0]` and bits 63:0 equal to `dst_in[63:0]`.
- R2: With `enc`=0, committed result bits VEC_W-1:128 equal `dst_in[VEC_W-1:128]`.
- R3: With `enc`=1 (prefix A) or `enc`=2 (prefix B), a committed result has bits 63:0 equal to `src_v[63:0]` and bits 127:64 equal to `src_rm[63:0]`, bit-exact for NaN and denormal patterns.
- R4: With `enc`=1 or `enc`=2, committed result bits VEC_W-1:128 are zero.
- R5: An addressing-mode field `mode` other than 2'b11 is a fault for every encoding class.
- R6: With `enc`=1, `len_l`=1 is a fault. In this class `len_ll` and `w_bit` have no effect.
- R7: With `enc`=2, a nonzero `len_ll` or `w_bit`=1 is a fault. In this class `len_l` has no effect.
- R8: `enc`=3 is a reserved class and always faults.
- R9: On a fault, `out_wen`=0, `out_ud`=1, and `out_data` keeps its previous value.
- R10: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high. `out_wen` and `out_ud` are never high without `out_valid`.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_wen` and `out_ud`, and zeroes `out_data`.
- R12: With `enc`=0, the inputs `len_l`, `len_ll` and `w_bit` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| enc | input | 2 | Encoding class: 0 legacy, 1 prefix A, 2 prefix B, 3 reserved |
| mode | input | 2 | Addressing-mode field; 2'b11 selects register operand |
| len_l | input | 1 | Vector-length bit of prefix A |
| len_ll | input | 2 | Vector-length field of prefix B |
| w_bit | input | 1 | Operand-width bit of prefix B |
| dst_in | input | VEC_W | Current destination register value |
| src_v | input | VEC_W | Extra-source register (low half for three-operand classes) |
| src_rm | input | VEC_W | Register/memory operand register |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_wen | output | 1 | Destination write-enable |
| out_ud | output | 1 | Invalid-opcode flag |
| out_data | output | VEC_W | Destination value |

## Verification
The bench goes after the ways the two classes handle the upper bits. A design that mixed them up would either leak `dst_in` above bit 127 into a three-operand result, or wipe those bits in a legacy result. The full-width compare shows both cases.

It also checks the fields that each class must ignore. A decoder that shared one length check across classes would fault a legal prefix-B operation that has `len_l` set, or a legal prefix-A operation with a nonzero `len_ll`.

Faults placed directly after a committed result show whether a faulting operation corrupts `out_data`. Back-to-back strobes show whether a design stretches or drops `out_valid`.

// File: rtl/qlh_pkg.sv
package qlh_pkg;

    localparam int QW_BITS   = 64;
    localparam int LANE_BITS = 128;

    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_PFX_A  = 2'd1,
        ENC_PFX_B  = 2'd2,
        ENC_RSVD   = 2'd3
    } enc_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_FAULT  = 2'd2
    } ostate_e;

    localparam logic [1:0] MODE_REG = 2'b11;

endpackage

// File: rtl/qlh_decode.sv
module qlh_decode
    import qlh_pkg::*;
(
    input  enc_e       enc,
    input  logic [1:0] mode,
    input  logic       len_l,
    input  logic [1:0] len_ll,
    input  logic       w_bit,
    output logic       fault,
    output logic       is_legacy
);

    logic class_fault;

    always_comb begin
        class_fault = 1'b0;
        is_legacy   = 1'b0;
        unique case (enc)
            ENC_LEGACY: is_legacy   = 1'b1;
            ENC_PFX_A:  class_fault = len_l;
            ENC_PFX_B:  class_fault = (len_ll != 2'b00) || w_bit;
            ENC_RSVD:   class_fault = 1'b1;
            default:    class_fault = 1'b1;
        endcase
        fault = class_fault || (mode != MODE_REG);
    end

endmodule

// File: rtl/qlh_datapath.sv
module qlh_datapath
    import qlh_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic             is_legacy,
    input  logic [VEC_W-1:0] dst_in,
    input  logic [VEC_W-1:0] src_v,
    input  logic [VEC_W-1:0] src_rm,
    output logic [VEC_W-1:0] result
);

    logic [QW_BITS-1:0] low_q;

    assign low_q = is_legacy ? dst_in[QW_BITS-1:0] : src_v[QW_BITS-1:0];
    assign result[QW_BITS-1:0]         = low_q;
    assign result[LANE_BITS-1:QW_BITS] = src_rm[QW_BITS-1:0];

    generate
        if (VEC_W > LANE_BITS) begin : g_upper
            localparam int UP_W = VEC_W - LANE_BITS;
            assign result[VEC_W-1:LANE_BITS] =
                is_legacy ? dst_in[VEC_W-1:LANE_BITS] : {UP_W{1'b0}};
        end else begin : g_no_upper
            logic unused_hi;
            assign unused_hi = ^{dst_in[QW_BITS +: QW_BITS],
                                 src_v[QW_BITS +: QW_BITS],
                                 src_rm[QW_BITS +: QW_BITS]};
        end
    endgenerate

endmodule

// File: rtl/qlh_merge.sv
module qlh_merge
    import qlh_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       enc,
    input  logic [1:0]       mode,
    input  logic             len_l,
    input  logic [1:0]       len_ll,
    input  logic             w_bit,
    input  logic [VEC_W-1:0] dst_in,
    input  logic [VEC_W-1:0] src_v,
    input  logic [VEC_W-1:0] src_rm,
    output logic             out_valid,
    output logic             out_wen,
    output logic             out_ud,
    output logic [VEC_W-1:0] out_data
);

    ostate_e          state_q, state_d;
    logic             fault;
    logic             is_legacy;
    logic [VEC_W-1:0] merged;
    logic [VEC_W-1:0] data_q;

    qlh_decode u_decode (
        .enc       (enc_e'(enc)),
        .mode      (mode),
        .len_l     (len_l),
        .len_ll    (len_ll),
        .w_bit     (w_bit),
        .fault     (fault),
        .is_legacy (is_legacy)
    );

    qlh_datapath #(.VEC_W(VEC_W)) u_datapath (
        .is_legacy (is_legacy),
        .dst_in    (dst_in),
        .src_v     (src_v),
        .src_rm    (src_rm),
        .result    (merged)
    );

    always_comb begin
        if (!in_valid)  state_d = ST_IDLE;
        else if (fault) state_d = ST_FAULT;
        else            state_d = ST_COMMIT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_COMMIT) data_q <= merged;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_wen   = 1'b0;
        out_ud    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: begin out_valid = 1'b1; out_wen = 1'b1; end
            ST_FAULT:  begin out_valid = 1'b1; out_ud  = 1'b1; end
            default:   ;
        endcase
        out_data = data_q;
    end

endmodule

// File: rtl/qlh_merge_chk.sv
module qlh_merge_chk #(
    parameter int VEC_W = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       enc,
    input logic [1:0]       mode,
    input logic [VEC_W-1:0] dst_in,
    input logic [VEC_W-1:0] src_v,
    input logic [VEC_W-1:0] src_rm,
    input logic             out_valid,
    input logic             out_wen,
    input logic             out_ud,
    input logic [VEC_W-1:0] out_data
);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_flags_qualified_R10: assert property (@(posedge clk) disable iff (rst)
        (out_wen || out_ud) |-> out_valid);

    assert_fault_holds_data_R9: assert property (@(posedge clk) disable iff (rst)
        out_ud |-> (!out_wen && $stable(out_data)));

    assert_mode_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != 2'b11) |=> out_ud);

    assert_reserved_fault_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && enc == 2'd3) |=> (out_ud && !out_wen));

    assert_legacy_high_R1: assert property (@(posedge clk) disable iff (rst)
        (out_wen && $past(enc) == 2'd0) |->
            (out_data[127:64] == $past(src_rm[63:0]) &&
             out_data[63:0]   == $past(dst_in[63:0])));

    assert_three_op_low_R3: assert property (@(posedge clk) disable iff (rst)
        (out_wen && $past(enc) != 2'd0) |->
            (out_data[63:0]   == $past(src_v[63:0]) &&
             out_data[127:64] == $past(src_rm[63:0])));

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_wen && !out_ud));

    generate
        if (VEC_W > 128) begin : g_upper_chk
            assert_three_op_upper_R4: assert property (@(posedge clk) disable iff (rst)
                (out_wen && $past(enc) != 2'd0) |-> (out_data[VEC_W-1:128] == '0));

            assert_legacy_upper_R2: assert property (@(posedge clk) disable iff (rst)
                (out_wen && $past(enc) == 2'd0) |->
                    (out_data[VEC_W-1:128] == $past(dst_in[VEC_W-1:128])));
        end
    endgenerate

endmodule

bind qlh_merge qlh_merge_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .enc       (enc),
    .mode      (mode),
    .dst_in    (dst_in),
    .src_v     (src_v),
    .src_rm    (src_rm),
    .out_valid (out_valid),
    .out_wen   (out_wen),
    .out_ud    (out_ud),
    .out_data  (out_data)
);

// File: tb/test_qlh_merge.sv
module test_qlh_merge;

    localparam int VW      = 512;
    localparam int CLK_PER = 10;
    localparam int NVEC    = 14;
    localparam int WD_MAX  = 5000;

    // entry: {enc[1:0], mode[1:0], len_l, len_ll[1:0], w_bit, expect_fault}
    localparam logic [8:0] VEC [NVEC] = '{
        {2'd0, 2'b11, 1'b0, 2'd0, 1'b0, 1'b0}, // R1 R2 legacy
        {2'd0, 2'b11, 1'b1, 2'd3, 1'b1, 1'b0}, // R12 legacy ignores len/w
        {2'd1, 2'b11, 1'b0, 2'd0, 1'b0, 1'b0}, // R3 R4 prefix A
        {2'd1, 2'b11, 1'b0, 2'd2, 1'b1, 1'b0}, // R6 A ignores len_ll, w
        {2'd1, 2'b11, 1'b1, 2'd0, 1'b0, 1'b1}, // R6 A len_l fault
        {2'd2, 2'b11, 1'b1, 2'd0, 1'b0, 1'b0}, // R7 B ignores len_l
        {2'd2, 2'b11, 1'b0, 2'd1, 1'b0, 1'b1}, // R7 B len_ll fault
        {2'd2, 2'b11, 1'b0, 2'd2, 1'b0, 1'b1}, // R7 B len_ll fault
        {2'd2, 2'b11, 1'b0, 2'd0, 1'b1, 1'b1}, // R7 B w fault
        {2'd0, 2'b10, 1'b0, 2'd0, 1'b0, 1'b1}, // R5 legacy mode
        {2'd1, 2'b00, 1'b0, 2'd0, 1'b0, 1'b1}, // R5 A mode
        {2'd2, 2'b01, 1'b0, 2'd0, 1'b0, 1'b1}, // R5 B mode
        {2'd3, 2'b11, 1'b0, 2'd0, 1'b0, 1'b1}, // R8 reserved
        {2'd2, 2'b11, 1'b0, 2'd0, 1'b0, 1'b0}  // R3 R4 prefix B
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [1:0]    enc, mode, len_ll;
    logic          len_l, w_bit;
    logic [VW-1:0] dst_in, src_v, src_rm;
    logic          out_valid, out_wen, out_ud;
    logic [VW-1:0] out_data;

    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;
    logic [VW-1:0] exp_data;

    always #(CLK_PER/2) clk = ~clk;

    qlh_merge #(.VEC_W(VW)) i_qlh_merge (
        .clk(clk), .rst(rst), .in_valid(in_valid), .enc(enc), .mode(mode),
        .len_l(len_l), .len_ll(len_ll), .w_bit(w_bit), .dst_in(dst_in),
        .src_v(src_v), .src_rm(src_rm), .out_valid(out_valid),
        .out_wen(out_wen), .out_ud(out_ud), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [VW-1:0] act, input logic [VW-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [VW-1:0] model(input logic [1:0] e,
        input logic [VW-1:0] d, input logic [VW-1:0] v, input logic [VW-1:0] r);
        logic [VW-1:0] m;
        if (e == 2'd0) m = {d[VW-1:128], r[63:0], d[63:0]};
        else           m = {{(VW-128){1'b0}}, r[63:0], v[63:0]};
        return m;
    endfunction

    task automatic drive(input logic [7:0] f, input int k);
        {enc, mode, len_l, len_ll, w_bit} = f;
        dst_in   = {8{64'hDDDD_0000_0000_0000 + 64'(k)}};
        src_v    = {8{64'h1111_2222_0000_0000 + 64'(k)}};
        src_rm   = {8{64'h7FC0_0001_0000_0001 ^ (64'(k) << 8)}};
        in_valid = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WD_MAX; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_MAX, WD_MAX);
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; enc = '0; mode = '0; len_l = 1'b0;
        len_ll = '0; w_bit = 1'b0; dst_in = '0; src_v = '0; src_rm = '0;
        exp_data = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!out_valid && !out_wen && !out_ud, "R11 flags", VW'({out_valid, out_wen, out_ud}), '0);
        check(out_data == '0, "R11 data", out_data, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R10 idle", VW'(out_valid), '0);

        for (int i = 0; i < NVEC; i++) begin
            bit fexp;
            fexp = VEC[i][0];
            drive(VEC[i][8:1], i);
            if (!fexp) exp_data = model(enc, dst_in, src_v, src_rm);
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid, "R10 strobe", VW'(out_valid), VW'(1));
            if (fexp) begin
                // R9 fault: no write, flag set, data held (also R5 R6 R7 R8)
                check(out_ud && !out_wen, "R9 flags", VW'({out_wen, out_ud}), VW'(2'b01));
                check(out_data == exp_data, "R9 data hold", out_data, exp_data);
            end else begin
                check(out_wen && !out_ud, "R12 R6 R7 legal", VW'({out_wen, out_ud}), VW'(2'b10));
                check(out_data == exp_data, (VEC[i][8:7] == 2'd0) ? "R1 R2" : "R3 R4",
                      out_data, exp_data);
            end
            @(negedge clk);
            check(!out_valid && !out_wen && !out_ud, "R10 single pulse",
                  VW'({out_valid, out_wen, out_ud}), '0);
        end

        // R10 back-to-back: legacy then prefix A, each one cycle
        drive({2'd0, 2'b11, 1'b0, 2'd0, 1'b0}, 40);
        exp_data = model(enc, dst_in, src_v, src_rm);
        @(negedge clk);
        check(out_valid && out_wen && out_data == exp_data, "R10 R1 b2b first", out_data, exp_data);
        drive({2'd1, 2'b11, 1'b0, 2'd0, 1'b0}, 41);
        exp_data = model(enc, dst_in, src_v, src_rm);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_wen && out_data == exp_data, "R10 R3 b2b second", out_data, exp_data);
        @(negedge clk);
        check(!out_valid, "R10 b2b end", VW'(out_valid), '0);

        // R11 reset after activity
        drive({2'd0, 2'b11, 1'b0, 2'd0, 1'b0}, 50);
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(!out_valid && !out_wen && !out_ud, "R11 mid flags",
              VW'({out_valid, out_wen, out_ud}), '0);
        check(out_data == '0, "R11 mid data", out_data, '0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule